// File: doc/BRIEF.md
# Indirect Memory Access Window

This block gives a host a narrow register window onto a much larger internal word memory and onto a small bank of peripheral registers. To reach the memory, the host loads a device address into a pointer register and then reads or writes a data register. Every data access moves its own pointer forward by one 32-bit word, so a block of consecutive words can be streamed without reloading the address. Reads and writes use two separate pointers that advance independently of each other.

The peripheral side uses the same approach, with one difference: its address word carries the register offset in its low half and a transfer size (byte count minus one) in bits 25..24. A partial write changes only the low-order bytes. A partial read returns only those bytes and zeroes the rest. Peripheral pointers do not auto-increment.

A memory pointer outside the backed data range, or a peripheral offset beyond the register bank, gives an all-ones read and a discarded write. Either event sets a sticky error flag that only reset clears.

Top module: `iaw_top`

## Requirements
- R1: After reset, host_rdata is 0, host_rvalid is 0, range_err is 0, and all four pointer registers read back as 0.
- R2: Host register offsets: 0x00C memory read pointer, 0x010 memory write pointer, 0x018 memory write data, 0x01C memory read data, 0x044 peripheral write address, 0x048 peripheral read address, 0x04C peripheral write data, 0x050 peripheral read data. A write to a pointer offset loads all 32 bits, and a read of it returns that value. Every read is answered with host_rvalid high and host_rdata valid exactly one clock after the request edge.
- R3: A write to 0x018 stores host_wdata at word (wptr-MEM_BASE)/4 and then advances the write pointer by 4.
- R4: A read of 0x01C returns the word at the read pointer and then advances the read pointer by 4. A data access on one pointer never changes the other pointer. A read issued right after a write to the same word returns the new data.
- R5: A memory address is valid only if MEM_BASE <= addr < MEM_BASE+4*MEM_WORDS (0x800000 to below 0x801000 by default; a full 8192-word build ends at 0x808000). An out-of-range read returns 0xFFFFFFFF, and an out-of-range write changes no memory word. The pointer still advances in both cases.
- R6: range_err goes to 1 on the cycle after any out-of-range memory or peripheral data access and stays at 1 until reset.
- R7: In a peripheral address word, bits 15..0 are the byte offset (register index = offset/4) and bits 25..24 are the byte count minus one. Peripheral data accesses leave both peripheral address registers unchanged.
- R8: A peripheral write with size field n updates bytes 0..n of the register and leaves the upper bytes unchanged.
- R9: A peripheral read with size field n returns bytes 0..n and zeroes in the upper bytes. An offset at or above 4*PRPH_REGS reads 0xFFFFFFFF and discards writes.
- R10: Unmapped offsets read 0, and writes to them have no effect. If write and read enables are both high, only the write is performed and host_rvalid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 12 | Host register byte offset within the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read response data |
| host_rvalid | output | 1 | Read response valid, one cycle after the request |
| range_err | output | 1 | Sticky out-of-range access flag |

## Verification
Read data, host_rvalid, pointer advances and range_err all appear one clock after the request edge. The bench drives each request on a falling edge and samples on the following falling edge, which is exactly one rising edge later. Because every host access is followed by an idle cycle, each sample reflects exactly one access. Pointer movement and partial-byte writes are checked at the ports: the bench reads the pointer registers back and reads the peripheral registers with full size.

// File: rtl/iaw_pkg.sv
package iaw_pkg;
    localparam int HOST_AW = 12;
    localparam int DW      = 32;

    localparam logic [HOST_AW-1:0] OFS_MEM_RPTR  = 12'h00C;
    localparam logic [HOST_AW-1:0] OFS_MEM_WPTR  = 12'h010;
    localparam logic [HOST_AW-1:0] OFS_MEM_WDATA = 12'h018;
    localparam logic [HOST_AW-1:0] OFS_MEM_RDATA = 12'h01C;
    localparam logic [HOST_AW-1:0] OFS_PR_WADDR  = 12'h044;
    localparam logic [HOST_AW-1:0] OFS_PR_RADDR  = 12'h048;
    localparam logic [HOST_AW-1:0] OFS_PR_WDATA  = 12'h04C;
    localparam logic [HOST_AW-1:0] OFS_PR_RDATA  = 12'h050;

    typedef struct packed {
        logic [DW-1:0] rptr;
        logic [DW-1:0] wptr;
        logic [DW-1:0] pr_waddr;
        logic [DW-1:0] pr_raddr;
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          err;
    } iaw_state_t;

    // Byte enables for a size field: bytes 0..sz active
    function automatic logic [3:0] size_to_be(input logic [1:0] sz);
        logic [3:0] be;
        for (int b = 0; b < 4; b++) be[b] = (2'(b) <= sz);
        return be;
    endfunction

    function automatic logic [DW-1:0] size_to_mask(input logic [1:0] sz);
        logic [DW-1:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = (2'(b) <= sz) ? 8'hFF : 8'h00;
        return m;
    endfunction
endpackage

// File: rtl/iaw_word_mem.sv
module iaw_word_mem #(
    parameter int WORDS = 1024,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rword
);
    logic [DW-1:0] store_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) store_q[widx] <= wdata;
    end

    assign rword = store_q[ridx];
endmodule

// File: rtl/iaw_prph_regs.sv
module iaw_prph_regs #(
    parameter int REGS = 16,
    localparam int IDX_W = $clog2(REGS),
    localparam int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LANES-1:0] be,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rword
);
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_q [REGS];
        logic [7:0] lane_d [REGS];

        always_comb begin
            for (int i = 0; i < REGS; i++) lane_d[i] = lane_q[i];
            if (we && be[b]) lane_d[widx] = wdata[8*b +: 8];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < REGS; i++) lane_q[i] <= '0;
            end else begin
                for (int i = 0; i < REGS; i++) lane_q[i] <= lane_d[i];
            end
        end

        assign rword[8*b +: 8] = lane_q[ridx];
    end
endmodule

// File: rtl/iaw_top.sv
module iaw_top
    import iaw_pkg::*;
#(
    parameter logic [31:0] MEM_BASE  = 32'h0080_0000,
    parameter int          MEM_WORDS = 1024,
    parameter int          PRPH_REGS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic               host_rvalid,
    output logic               range_err
);
    localparam int          MIDX_W    = $clog2(MEM_WORDS);
    localparam int          PIDX_W    = $clog2(PRPH_REGS);
    localparam logic [31:0] MEM_LIMIT = MEM_BASE + 32'(MEM_WORDS * 4);
    localparam logic [31:0] PR_SPAN   = 32'(PRPH_REGS * 4);
    localparam logic [31:0] WORD_STEP = 32'd4;

    iaw_state_t st_d, st_q;

    logic              do_wr, do_rd;
    logic              rptr_ok, wptr_ok, prr_ok, prw_ok;
    logic [31:0]       roff, woff;
    logic [MIDX_W-1:0] mem_ridx, mem_widx;
    logic [DW-1:0]     mem_rword;
    logic              mem_we;
    logic [PIDX_W-1:0] pr_ridx, pr_widx;
    logic [DW-1:0]     pr_rword;
    logic              pr_we;
    logic [3:0]        pr_be;

    // Request decode: a write wins over a simultaneous read
    assign do_wr = host_wr_en;
    assign do_rd = host_rd_en && !host_wr_en;

    // Range checks on the current pointers
    assign rptr_ok = (st_q.rptr >= MEM_BASE) && (st_q.rptr < MEM_LIMIT);
    assign wptr_ok = (st_q.wptr >= MEM_BASE) && (st_q.wptr < MEM_LIMIT);
    assign prr_ok  = {16'h0, st_q.pr_raddr[15:0]} < PR_SPAN;
    assign prw_ok  = {16'h0, st_q.pr_waddr[15:0]} < PR_SPAN;

    assign roff     = st_q.rptr - MEM_BASE;
    assign woff     = st_q.wptr - MEM_BASE;
    assign mem_ridx = MIDX_W'(roff >> 2);
    assign mem_widx = MIDX_W'(woff >> 2);
    assign pr_ridx  = PIDX_W'(st_q.pr_raddr[15:2]);
    assign pr_widx  = PIDX_W'(st_q.pr_waddr[15:2]);
    assign pr_be    = size_to_be(st_q.pr_waddr[25:24]);

    iaw_word_mem #(.WORDS(MEM_WORDS), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .widx  (mem_widx),
        .wdata (host_wdata),
        .ridx  (mem_ridx),
        .rword (mem_rword)
    );

    iaw_prph_regs #(.REGS(PRPH_REGS)) u_prph (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pr_we),
        .be    (pr_be),
        .widx  (pr_widx),
        .wdata (host_wdata),
        .ridx  (pr_ridx),
        .rword (pr_rword)
    );

    // Next-state logic
    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        mem_we      = 1'b0;
        pr_we       = 1'b0;
        if (do_wr) begin
            case (host_addr)
                OFS_MEM_RPTR:  st_d.rptr     = host_wdata;
                OFS_MEM_WPTR:  st_d.wptr     = host_wdata;
                OFS_PR_WADDR:  st_d.pr_waddr = host_wdata;
                OFS_PR_RADDR:  st_d.pr_raddr = host_wdata;
                OFS_MEM_WDATA: begin
                    st_d.wptr = st_q.wptr + WORD_STEP;
                    if (wptr_ok) mem_we   = 1'b1;
                    else         st_d.err = 1'b1;
                end
                OFS_PR_WDATA: begin
                    if (prw_ok) pr_we    = 1'b1;
                    else        st_d.err = 1'b1;
                end
                default: ;
            endcase
        end else if (do_rd) begin
            st_d.rvalid = 1'b1;
            case (host_addr)
                OFS_MEM_RPTR:  st_d.rdata = st_q.rptr;
                OFS_MEM_WPTR:  st_d.rdata = st_q.wptr;
                OFS_PR_WADDR:  st_d.rdata = st_q.pr_waddr;
                OFS_PR_RADDR:  st_d.rdata = st_q.pr_raddr;
                OFS_MEM_RDATA: begin
                    st_d.rptr = st_q.rptr + WORD_STEP;
                    if (rptr_ok) begin
                        st_d.rdata = mem_rword;
                    end else begin
                        st_d.rdata = '1;
                        st_d.err   = 1'b1;
                    end
                end
                OFS_PR_RDATA: begin
                    if (prr_ok) begin
                        st_d.rdata = pr_rword & size_to_mask(st_q.pr_raddr[25:24]);
                    end else begin
                        st_d.rdata = '1;
                        st_d.err   = 1'b1;
                    end
                end
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
    assign range_err   = st_q.err;

    // R6: the error flag never drops once set
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> range_err);

    // R2: every lone read is answered one cycle later
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !host_wr_en) |=> host_rvalid);

    // R10: a colliding read is dropped
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && host_wr_en) |=> !host_rvalid);

    // R4: read data access steps the read pointer by one word
    a_r4_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && host_addr == OFS_MEM_RDATA) |=> st_q.rptr == $past(st_q.rptr) + WORD_STEP);

    // R4: write data access leaves the read pointer alone
    a_r4_rptr_indep: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && host_addr == OFS_MEM_WDATA) |=> $stable(st_q.rptr));

    // R3: write data access steps the write pointer by one word
    a_r3_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && host_addr == OFS_MEM_WDATA) |=> st_q.wptr == $past(st_q.wptr) + WORD_STEP);

    // R5: out-of-range read yields all ones
    a_r5_oob_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && host_addr == OFS_MEM_RDATA && !rptr_ok) |=> host_rdata == '1);

    // R7: peripheral data accesses keep both peripheral addresses
    a_r7_prph_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((do_rd && host_addr == OFS_PR_RDATA) || (do_wr && host_addr == OFS_PR_WDATA))
        |=> ($stable(st_q.pr_raddr) && $stable(st_q.pr_waddr)));
endmodule

// File: tb/tb_iaw_top.sv
`timescale 1ns/1ps
module tb_iaw_top;
    localparam logic [31:0] BASE   = 32'h0080_0000;
    localparam int          WORDS  = 1024;
    localparam int          PREGS  = 16;
    localparam logic [31:0] LIMIT  = BASE + 32'(WORDS * 4);
    localparam logic [31:0] PSPAN  = 32'(PREGS * 4);
    localparam int          WD_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        range_err;

    always #2.5 clk = ~clk;

    iaw_top #(.MEM_BASE(BASE), .MEM_WORDS(WORDS), .PRPH_REGS(PREGS)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .range_err(range_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [31:0] m_mem [WORDS];
    logic [31:0] m_prf [PREGS];
    logic [31:0] m_rptr, m_wptr, m_prw, m_prr;
    logic        m_err;

    function automatic bit in_mem(input logic [31:0] a);
        return (a >= BASE) && (a < LIMIT);
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = (2'(b) <= sz) ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic void mdl_write(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] mk;
        case (a)
            12'h00C: m_rptr = d;
            12'h010: m_wptr = d;
            12'h044: m_prw  = d;
            12'h048: m_prr  = d;
            12'h018: begin
                if (in_mem(m_wptr)) m_mem[(m_wptr - BASE) >> 2] = d;
                else                m_err = 1'b1;
                m_wptr = m_wptr + 32'd4;
            end
            12'h04C: begin
                if ({16'h0, m_prw[15:0]} < PSPAN) begin
                    mk = lane_mask(m_prw[25:24]);
                    m_prf[m_prw[15:2]] = (m_prf[m_prw[15:2]] & ~mk) | (d & mk);
                end else m_err = 1'b1;
            end
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] mdl_read(input logic [11:0] a);
        logic [31:0] r;
        case (a)
            12'h00C: r = m_rptr;
            12'h010: r = m_wptr;
            12'h044: r = m_prw;
            12'h048: r = m_prr;
            12'h01C: begin
                if (in_mem(m_rptr)) r = m_mem[(m_rptr - BASE) >> 2];
                else begin r = '1; m_err = 1'b1; end
                m_rptr = m_rptr + 32'd4;
            end
            12'h050: begin
                if ({16'h0, m_prr[15:0]} < PSPAN) r = m_prf[m_prr[15:2]] & lane_mask(m_prr[25:24]);
                else begin r = '1; m_err = 1'b1; end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        mdl_write(a, d);
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hr(input string req, input logic [11:0] a);
        logic [31:0] exp;
        @(negedge clk);
        host_rd_en = 1'b1; host_addr = a;
        exp = mdl_read(a);
        @(negedge clk);
        host_rd_en = 1'b0;
        chk(req, host_rdata, exp);
        chk(req, 32'(host_rvalid), 32'd1);
    endtask

    function automatic logic [31:0] rnd_mem_addr();
        int sel = int'($urandom % 8);
        if (sel == 0) return BASE - 32'd4 * (($urandom % 4) + 1);
        if (sel == 1) return LIMIT - 32'd4 * ($urandom % 3);
        return BASE + 32'd4 * ($urandom % WORDS);
    endfunction

    initial begin
        #(WD_CYC * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7421));
        m_rptr = '0; m_wptr = '0; m_prw = '0; m_prr = '0; m_err = 1'b0;
        for (int i = 0; i < PREGS; i++) m_prf[i] = '0;
        for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", host_rdata, 32'h0);
        chk("R1 rvalid", 32'(host_rvalid), 32'd0);
        chk("R1 range_err", 32'(range_err), 32'd0);
        hr("R1 rptr", 12'h00C);
        hr("R1 wptr", 12'h010);
        hr("R1 prw", 12'h044);
        hr("R1 prr", 12'h048);

        // R2 pointer load and read back
        hw(12'h00C, 32'hDEAD_BEEF); hr("R2 rptr load", 12'h00C);
        hw(12'h048, 32'h1234_5678); hr("R2 prr load", 12'h048);

        // R3 fill the whole memory by streaming
        hw(12'h010, BASE);
        for (int i = 0; i < WORDS; i++) hw(12'h018, 32'hA500_0000 ^ (32'(i) * 32'h0001_0003));
        hr("R3 wptr after stream", 12'h010);
        chk("R3 wptr value", m_wptr, LIMIT);
        chk("R6 no error yet", 32'(range_err), 32'd0);

        // R4 streaming reads, independence, read after write
        hw(12'h00C, BASE + 32'd8);
        hr("R4 stream0", 12'h01C); hr("R4 stream1", 12'h01C); hr("R4 stream2", 12'h01C);
        hr("R4 rptr step", 12'h00C);
        hw(12'h00C, BASE); hw(12'h010, BASE + 32'd4);
        hr("R4 word0", 12'h01C);
        hw(12'h018, 32'hCAFE_F00D);
        hr("R4 rptr indep", 12'h00C);
        hr("R4 read after write", 12'h01C);
        hr("R4 wptr indep", 12'h010);

        // R5/R6 boundary
        hw(12'h00C, LIMIT - 32'd4);
        hr("R5 last word", 12'h01C);
        chk("R6 still clear", 32'(range_err), 32'd0);
        hr("R5 past limit ones", 12'h01C);
        chk("R6 set", 32'(range_err), 32'd1);
        hw(12'h010, BASE - 32'd4);
        hw(12'h018, 32'h5555_AAAA);
        hw(12'h00C, LIMIT - 32'd4);
        hr("R5 oob write discarded", 12'h01C);
        hw(12'h00C, BASE);
        hr("R5 first word intact", 12'h01C);
        chk("R6 sticky", 32'(range_err), 32'd1);

        // R7/R8/R9 peripheral window
        hw(12'h044, 32'h0300_0008); hw(12'h04C, 32'hA1B2_C3D4);
        hw(12'h048, 32'h0300_0008); hr("R8 full write", 12'h050);
        hw(12'h044, 32'h0000_0008); hw(12'h04C, 32'hFFFF_FFEE);
        hr("R8 one byte", 12'h050);
        hw(12'h044, 32'h0100_0008); hw(12'h04C, 32'h9999_7766);
        hr("R8 two bytes", 12'h050);
        hw(12'h048, 32'h0100_0008); hr("R9 two byte read", 12'h050);
        hw(12'h048, 32'h0200_0008); hr("R9 three byte read", 12'h050);
        hr("R7 prr unchanged", 12'h048);
        hr("R7 prw unchanged", 12'h044);
        hw(12'h048, 32'h0300_0000 | PSPAN); hr("R9 oob ones", 12'h050);
        hw(12'h044, 32'h0300_0000 | PSPAN); hw(12'h04C, 32'h0);
        hw(12'h048, 32'h0300_0008); hr("R9 oob write discarded", 12'h050);

        // R10 unmapped and collision
        hw(12'h020, 32'h1111_2222); hr("R10 unmapped read", 12'h020);
        hr("R10 unmapped 0x14", 12'h014);
        @(negedge clk);
        host_wr_en = 1'b1; host_rd_en = 1'b1; host_addr = 12'h010; host_wdata = BASE + 32'h40;
        mdl_write(12'h010, BASE + 32'h40);
        @(negedge clk);
        host_wr_en = 1'b0; host_rd_en = 1'b0;
        chk("R10 no rvalid on collision", 32'(host_rvalid), 32'd0);
        hr("R10 write took effect", 12'h010);

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            int op = int'($urandom % 10);
            case (op)
                0: hw(12'h00C, rnd_mem_addr());
                1: hw(12'h010, rnd_mem_addr());
                2, 3: hw(12'h018, $urandom);
                4, 5: hr("R4 random read", 12'h01C);
                6: hr("R3 random ptr", (($urandom % 2) == 0) ? 12'h00C : 12'h010);
                7: hw((($urandom % 2) == 0) ? 12'h044 : 12'h048,
                      {6'h0, 2'($urandom), 8'h0, 16'($urandom % 72) & 16'hFFFC});
                8: hw(12'h04C, $urandom);
                default: hr("R9 random prph read", 12'h050);
            endcase
        end
        chk("R6 final flag", 32'(range_err), 32'(m_err));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule